// File: doc/BRIEF.md
# Sleep and Wake-Up Sequencer

This block sits beside a small 8-bit processor core and carries out the power-down step of a sleep instruction. When the core strobes a sleep request and no interrupt source is both enabled and flagged, the sequencer stops the core clock, clears the watchdog counter (which keeps counting), clears the power-down status bit and sets the time-out status bit. If a source is already enabled and flagged when the request arrives, the sleep becomes a no-op: the clock keeps running and neither the watchdog nor the status bits change.

While asleep, three events end the power-down. An external reset raises a reset request. A watchdog time-out and an interrupt source both let program execution continue. An interrupt wakes the core whatever the global interrupt enable says. That enable only decides whether the core branches to the interrupt vector once the instruction after the sleep has completed. Every wake-up clears the watchdog. A watchdog wake also clears the time-out bit.

The power-down bit is set only by power-up reset. Software can therefore read it to tell whether a sleep really took effect.

Top module: `swc_sleep_ctrl`

## Requirements
- R1: After power-up reset, clock-enable is 1, the power-down bit is 1, the time-out bit is 1, and the watchdog-clear, resume, vector and reset-request pulses are all 0.
- R2: A sleep request while running, with no source i having both int_en[i] and int_flag[i] set, gives the following in the next cycle: clock-enable 0, power-down bit 0, time-out bit 1, and a one-cycle watchdog-clear pulse.
- R3: A sleep request while such a source is pending is a no-op. Clock-enable stays 1, both status bits keep their values, and no watchdog-clear pulse is produced. The power-down bit never returns to 1 except through power-up reset.
- R4: While asleep, the first cycle in which some source is enabled and flagged produces, one cycle later, clock-enable 1, a one-cycle resume pulse and a one-cycle watchdog-clear pulse. This happens whatever the value of gie, and the status bits are unchanged. A flag whose enable bit is 0 does not wake the core.
- R5: On an interrupt wake, if gie was 0 no vector pulse follows. If gie was 1, one vector pulse follows, one cycle after the first insn_done strobe that comes after the wake.
- R6: A watchdog time-out while asleep wakes the core. One cycle later it clears the time-out bit and produces a resume pulse and a watchdog-clear pulse. No vector pulse follows, even with gie set.
- R7: An external reset while asleep produces, one cycle later, a one-cycle reset-request pulse, clock-enable 1 and a watchdog-clear pulse. It produces no resume pulse and leaves the status bits unchanged.
- R8: When wake causes coincide, external reset takes priority over watchdog time-out, and watchdog time-out takes priority over an interrupt source.
- R9: While awake, watchdog time-out and insn_done outside the vector wait have no effect. An external reset while awake produces only a reset-request pulse and cancels a pending vector branch.
- R10: A sleep request that arrives while the core is waiting to issue a vector branch is ignored.
- R11: vec_addr always equals the VEC_ADDR parameter (default 0x0004).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sleep_req | input | 1 | Sleep-instruction execute strobe |
| int_en | input | NUM_SRC | Per-source interrupt enable bits |
| int_flag | input | NUM_SRC | Per-source interrupt flag bits |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| ext_reset | input | 1 | External reset request input |
| insn_done | input | 1 | Core instruction-complete strobe |
| clk_en | output | 1 | Core clock enable |
| stat_pd | output | 1 | Power-down status bit |
| stat_to | output | 1 | Time-out status bit |
| wdt_clr | output | 1 | Watchdog clear pulse |
| resume | output | 1 | Execution-continues pulse |
| vec_req | output | 1 | Branch-to-vector request pulse |
| vec_addr | output | ADDR_W | Interrupt vector address |
| reset_req | output | 1 | Device reset request pulse |

## Verification
Every result of this block comes from a single register stage. A sleep request, a wake cause or an insn_done seen at one rising edge shows its effect on clock-enable, status bits or pulses exactly one cycle later, and a pulse lasts one cycle. The bench drives inputs on falling edges and updates a behavioural model at each rising edge from the same inputs. It compares every output against that model at the next falling edge, so every result is checked in the cycle it is due and also in the cycles where it must stay low. Directed checks sample one falling edge after each stimulus.

// File: rtl/swc_pkg.sv
package swc_pkg;

   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_SLEEP    = 2'd1,
      ST_VEC_WAIT = 2'd2
   } swc_state_e;

   typedef struct packed {
      logic sleep_done;
      logic wake_int;
      logic wake_wdt;
      logic wake_rst;
      logic rst_any;
      logic vec_fire;
   } swc_evt_t;

endpackage

// File: rtl/swc_pending.sv
module swc_pending #(
   parameter int NUM_SRC = 6
) (
   input  logic [NUM_SRC-1:0] int_en,
   input  logic [NUM_SRC-1:0] int_flag,
   output logic               pending
);
   logic [NUM_SRC-1:0] hit;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign hit[g] = int_en[g] & int_flag[g];
   end

   assign pending = |hit;
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
   import swc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sleep_req,
   input  logic     pending,
   input  logic     gie,
   input  logic     wdt_timeout,
   input  logic     ext_reset,
   input  logic     insn_done,
   output logic     clk_en,
   output swc_evt_t evt
);
   swc_state_e state_q, state_d;
   logic       clk_en_d;

   always_comb begin
      state_d  = state_q;
      clk_en_d = clk_en;
      evt      = '0;
      if (ext_reset) begin
         evt.rst_any  = 1'b1;
         evt.wake_rst = (state_q == ST_SLEEP);
         state_d      = ST_RUN;
         clk_en_d     = 1'b1;
      end else begin
         case (state_q)
            ST_RUN: begin
               if (sleep_req && !pending) begin
                  evt.sleep_done = 1'b1;
                  state_d        = ST_SLEEP;
                  clk_en_d       = 1'b0;
               end
            end
            ST_SLEEP: begin
               if (wdt_timeout) begin
                  evt.wake_wdt = 1'b1;
                  state_d      = ST_RUN;
                  clk_en_d     = 1'b1;
               end else if (pending) begin
                  evt.wake_int = 1'b1;
                  state_d      = gie ? ST_VEC_WAIT : ST_RUN;
                  clk_en_d     = 1'b1;
               end
            end
            ST_VEC_WAIT: begin
               if (insn_done) begin
                  evt.vec_fire = 1'b1;
                  state_d      = ST_RUN;
               end
            end
            default: state_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         clk_en  <= 1'b1;
      end else begin
         state_q <= state_d;
         clk_en  <= clk_en_d;
      end
   end

   p_sleep_gates_clock_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && sleep_req && !pending && !ext_reset) |=> (!clk_en && state_q == ST_SLEEP));

   p_noop_keeps_clock_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && sleep_req && pending && !ext_reset) |=> (clk_en && state_q == ST_RUN));

   p_wake_restores_clock_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && (pending || wdt_timeout || ext_reset)) |=> clk_en);

   p_vec_wait_ignores_sleep_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_VEC_WAIT && !ext_reset) |=> clk_en);
endmodule

// File: rtl/swc_status.sv
module swc_status (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_done,
   input  logic wake_wdt,
   output logic stat_pd,
   output logic stat_to
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_pd <= 1'b1;
         stat_to <= 1'b1;
      end else begin
         if (sleep_done) begin
            stat_pd <= 1'b0;
            stat_to <= 1'b1;
         end else if (wake_wdt) begin
            stat_to <= 1'b0;
         end
      end
   end

   p_sleep_status_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      sleep_done |=> (!stat_pd && stat_to));

   p_wdt_clears_to_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      wake_wdt |=> !stat_to);

   p_pd_sticky_low_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !stat_pd |=> !stat_pd);
endmodule

// File: rtl/swc_pulses.sv
module swc_pulses
   import swc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  swc_evt_t evt,
   output logic     wdt_clr,
   output logic     resume,
   output logic     reset_req,
   output logic     vec_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdt_clr   <= 1'b0;
         resume    <= 1'b0;
         reset_req <= 1'b0;
         vec_req   <= 1'b0;
      end else begin
         wdt_clr   <= evt.sleep_done | evt.wake_int | evt.wake_wdt | evt.wake_rst;
         resume    <= evt.wake_int | evt.wake_wdt;
         reset_req <= evt.rst_any;
         vec_req   <= evt.vec_fire;
      end
   end

   p_single_cause_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resume, reset_req}));

   p_vec_one_cycle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |=> !vec_req);
endmodule

// File: rtl/swc_sleep_ctrl.sv
module swc_sleep_ctrl
   import swc_pkg::*;
#(
   parameter int               NUM_SRC  = 6,
   parameter int               ADDR_W   = 13,
   parameter logic [ADDR_W-1:0] VEC_ADDR = 13'h0004
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_req,
   input  logic [NUM_SRC-1:0] int_en,
   input  logic [NUM_SRC-1:0] int_flag,
   input  logic               gie,
   input  logic               wdt_timeout,
   input  logic               ext_reset,
   input  logic               insn_done,
   output logic               clk_en,
   output logic               stat_pd,
   output logic               stat_to,
   output logic               wdt_clr,
   output logic               resume,
   output logic               vec_req,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               reset_req
);
   if (NUM_SRC < 1) begin : g_bad_src
      $error("swc_sleep_ctrl: NUM_SRC must be at least 1");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("swc_sleep_ctrl: ADDR_W too small for the vector");
   end

   logic     pending;
   swc_evt_t evt;

   swc_pending #(.NUM_SRC(NUM_SRC)) i_pending (
      .int_en   (int_en),
      .int_flag (int_flag),
      .pending  (pending)
   );

   swc_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .pending     (pending),
      .gie         (gie),
      .wdt_timeout (wdt_timeout),
      .ext_reset   (ext_reset),
      .insn_done   (insn_done),
      .clk_en      (clk_en),
      .evt         (evt)
   );

   swc_status i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_done (evt.sleep_done),
      .wake_wdt   (evt.wake_wdt),
      .stat_pd    (stat_pd),
      .stat_to    (stat_to)
   );

   swc_pulses i_pulses (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .wdt_clr   (wdt_clr),
      .resume    (resume),
      .reset_req (reset_req),
      .vec_req   (vec_req)
   );

   assign vec_addr = VEC_ADDR;

   p_vec_after_done_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> $past(insn_done));

   p_vec_clock_on_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> clk_en);

   p_reset_req_clock_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> clk_en);

   p_vec_addr_fixed_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      vec_addr == VEC_ADDR);
endmodule

// File: tb/test_swc_sleep_ctrl.sv
module test_swc_sleep_ctrl;
   localparam int N = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sleep_req = 1'b0;
   logic [N-1:0] int_en = '0;
   logic [N-1:0] int_flag = '0;
   logic         gie = 1'b0;
   logic         wdt_timeout = 1'b0;
   logic         ext_reset = 1'b0;
   logic         insn_done = 1'b0;
   logic         clk_en, stat_pd, stat_to, wdt_clr, resume, vec_req, reset_req;
   logic [12:0]  vec_addr;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   swc_sleep_ctrl i_swc_sleep_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .int_en(int_en),
      .int_flag(int_flag), .gie(gie), .wdt_timeout(wdt_timeout),
      .ext_reset(ext_reset), .insn_done(insn_done), .clk_en(clk_en),
      .stat_pd(stat_pd), .stat_to(stat_to), .wdt_clr(wdt_clr),
      .resume(resume), .vec_req(vec_req), .vec_addr(vec_addr),
      .reset_req(reset_req)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d",
                  req, what, act, exp, cycles);
      end
   endtask

   // Behavioural reference model: 0 running, 1 asleep, 2 waiting to vector
   int   ms;
   logic m_clk, m_pd, m_to, m_wclr, m_res, m_rr, m_vr, m_pend;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         ms = 0; m_clk = 1; m_pd = 1; m_to = 1;
         m_wclr = 0; m_res = 0; m_rr = 0; m_vr = 0;
      end else begin
         m_pend = |(int_en & int_flag);
         m_wclr = 0; m_res = 0; m_rr = 0; m_vr = 0;
         if (ext_reset) begin
            m_rr = 1;
            if (ms == 1) begin m_wclr = 1; m_clk = 1; end
            ms = 0;
         end else if (ms == 0) begin
            if (sleep_req && !m_pend) begin
               ms = 1; m_clk = 0; m_pd = 0; m_to = 1; m_wclr = 1;
            end
         end else if (ms == 1) begin
            if (wdt_timeout) begin
               m_to = 0; m_wclr = 1; m_res = 1; m_clk = 1; ms = 0;
            end else if (m_pend) begin
               m_wclr = 1; m_res = 1; m_clk = 1; ms = gie ? 2 : 0;
            end
         end else begin
            if (insn_done) begin m_vr = 1; ms = 0; end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cycles > 1) begin
         check("R2", "clk_en",   clk_en,    m_clk);
         check("R3", "stat_pd",  stat_pd,   m_pd);
         check("R6", "stat_to",  stat_to,   m_to);
         check("R4", "wdt_clr",  wdt_clr,   m_wclr);
         check("R4", "resume",   resume,    m_res);
         check("R5", "vec_req",  vec_req,   m_vr);
         check("R7", "reset_req", reset_req, m_rr);
         check("R11", "vec_addr", vec_addr, 32'h4);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(3);
      // R1 reset state
      check("R1", "clk_en", clk_en, 1);
      check("R1", "stat_pd", stat_pd, 1);
      check("R1", "stat_to", stat_to, 1);
      check("R1", "pulses", {wdt_clr, resume, vec_req, reset_req}, 0);
      rst_n = 1'b1;
      step(2);

      // R3: pending source makes sleep a no-op
      int_en = 6'b000100; int_flag = 6'b000100;
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      check("R3", "noop clk_en", clk_en, 1);
      check("R3", "noop stat_pd", stat_pd, 1);
      check("R3", "noop wdt_clr", wdt_clr, 0);
      int_flag = '0; step(2);

      // R2: real sleep
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      check("R2", "clk_en off", clk_en, 0);
      check("R2", "stat_pd", stat_pd, 0);
      check("R2", "wdt_clr", wdt_clr, 1);
      step(3);
      // R4: flag without enable does not wake
      int_en = 6'b000100; int_flag = 6'b100000; step(3);
      check("R4", "no wake unenabled", clk_en, 0);
      // R4/R5: enabled flag wakes with gie=0, no vector
      int_flag = 6'b100100; step(1);
      check("R4", "wake clk_en", clk_en, 1);
      check("R4", "resume", resume, 1);
      int_flag = '0; insn_done = 1'b1; step(1); insn_done = 1'b0;
      check("R5", "no vector gie0", vec_req, 0);
      step(2);

      // R5/R11: gie=1 wake vectors after insn_done; R10 sleep ignored in wait
      gie = 1'b1;
      sleep_req = 1'b1; step(1); sleep_req = 1'b0; step(2);
      int_flag = 6'b000100; step(1); int_flag = '0;
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      check("R10", "sleep ignored", clk_en, 1);
      step(2);
      insn_done = 1'b1; step(1); insn_done = 1'b0;
      check("R5", "vector pulse", vec_req, 1);
      check("R11", "vector addr", vec_addr, 32'h4);
      step(1);
      check("R5", "vector one cycle", vec_req, 0);

      // R6/R8: watchdog and interrupt together
      sleep_req = 1'b1; step(1); sleep_req = 1'b0; step(2);
      wdt_timeout = 1'b1; int_flag = 6'b000100; step(1);
      wdt_timeout = 1'b0; int_flag = '0;
      check("R6", "stat_to cleared", stat_to, 0);
      check("R8", "wdt wins resume", resume, 1);
      insn_done = 1'b1; step(1); insn_done = 1'b0;
      check("R6", "no vector on wdt", vec_req, 0);

      // R7/R8: external reset and watchdog together
      sleep_req = 1'b1; step(1); sleep_req = 1'b0; step(2);
      ext_reset = 1'b1; wdt_timeout = 1'b1; step(1);
      ext_reset = 1'b0; wdt_timeout = 1'b0;
      check("R7", "reset_req", reset_req, 1);
      check("R8", "no resume", resume, 0);
      check("R7", "stat_to kept", stat_to, 1);

      // R9: awake stimuli
      step(1);
      wdt_timeout = 1'b1; insn_done = 1'b1; step(1);
      wdt_timeout = 1'b0; insn_done = 1'b0;
      check("R9", "awake quiet", {wdt_clr, resume, vec_req, reset_req, stat_to}, 1);
      sleep_req = 1'b1; step(1); sleep_req = 1'b0; step(1);
      int_flag = 6'b000100; step(1); int_flag = '0;
      ext_reset = 1'b1; step(1); ext_reset = 1'b0;
      insn_done = 1'b1; step(1); insn_done = 1'b0;
      check("R9", "vector cancelled", vec_req, 0);

      // random phase compared against the model each cycle
      for (int i = 0; i < 600; i++) begin
         sleep_req   = ($urandom % 4) == 0;
         int_en      = 6'($urandom);
         int_flag    = (($urandom % 5) == 0) ? 6'($urandom) : '0;
         gie         = $urandom % 2;
         wdt_timeout = ($urandom % 9) == 0;
         ext_reset   = ($urandom % 25) == 0;
         insn_done   = ($urandom % 3) == 0;
         step(1);
      end
      {sleep_req, wdt_timeout, ext_reset, insn_done} = '0;
      step(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule